// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block takes one inter-processor interrupt command and works out which of `N` local interrupt controllers it reaches. The command supplies a destination byte, a physical/logical mode bit, a 2-bit shorthand, a 3-bit delivery mode and the index of the sending controller. For each controller the block is given an 8-bit physical ID, an 8-bit logical ID, a 2-bit logical addressing model and an enable bit. The destination byte is normally taken from the top byte of the command's high word. The physical ID and logical ID are the top bytes of each controller's identity and logical destination registers.

Each command is presented for one cycle with `cmd_valid`. One clock later the block gives an `N`-bit mask of the enabled controllers that match. For lowest-priority delivery it also gives a one-hot choice of a single controller, which is the highest-numbered bit of that mask. A flag reports any controller whose logical model code is not recognised. Delivering the vector itself is left to the surrounding logic.

Top module: `ipi_dest_match`

## Requirements
- R1: With shorthand 2'b00 and `cmd_logical`=0, an enabled controller matches when `cmd_dest` is 8'hFF or equals its physical ID.
- R2: With shorthand 2'b00, `cmd_logical`=1 and model code 2'b00 (flat), an enabled controller matches when its logical ID AND `cmd_dest` is nonzero.
- R3: With shorthand 2'b00, `cmd_logical`=1 and model code 2'b01 (cluster), an enabled controller matches when the upper nibble of its logical ID equals the upper nibble of `cmd_dest`, and the lower nibbles of the two share at least one set bit.
- R4: With shorthand 2'b00 and `cmd_logical`=1, an enabled controller with model code 2'b10 or 2'b11 never matches and sets `res_model_err`. The flag stays 0 in every other case.
- R5: Shorthand 2'b01 (self) matches only the controller whose index equals `cmd_src`, whatever `cmd_dest` and `cmd_logical` hold.
- R6: Shorthand 2'b10 (all including self) matches every enabled controller.
- R7: Shorthand 2'b11 (all excluding self) matches every enabled controller except index `cmd_src`.
- R8: A controller whose `tgt_enable` bit is 0 never appears in `res_mask` or `res_lowest`.
- R9: When `cmd_dm` is 3'b001 (lowest priority), `res_lowest` is one-hot on the highest-numbered set bit of `res_mask`, or zero when the mask is empty. For every other delivery mode `res_lowest` is zero.
- R10: Results appear with `res_valid` in the cycle after `cmd_valid` is sampled. When `res_valid` is 0, all result outputs are zero, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_dest | input | 8 | Destination byte |
| cmd_logical | input | 1 | 0 selects physical addressing, 1 selects logical addressing |
| cmd_sh | input | 2 | Shorthand: 00 none, 01 self, 10 all, 11 all but self |
| cmd_dm | input | 3 | Delivery mode; 001 is lowest priority |
| cmd_src | input | $clog2(N) | Index of the sending controller |
| tgt_phys_id | input | 8*N | Physical ID of each controller; controller i uses bits [8i+7:8i] |
| tgt_log_id | input | 8*N | Logical ID of each controller |
| tgt_model | input | 2*N | Logical model of each controller: 00 flat, 01 cluster, other codes invalid |
| tgt_enable | input | N | Controller present and enabled |
| res_valid | output | 1 | Result valid |
| res_mask | output | N | Matching controllers |
| res_lowest | output | N | One-hot lowest-priority choice |
| res_model_err | output | 1 | An enabled controller had an invalid model |

## Verification
Several properties are checked on every cycle:
- The lowest-priority choice is at most one-hot and lies inside the mask.
- A non-empty mask in lowest-priority mode always yields a choice.
- Disabled controllers never reach the mask.
- A self command reaches at most one controller.
- The outputs are quiet whenever no result is valid.

Only the bench scenarios can show that the right controllers are chosen. These cover the ID comparisons, the broadcast byte, flat and cluster nibble matching, the exclusion of the sender, and the pick of the highest-numbered bit rather than some other bit.

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int N  = 8,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_dest,
  input  logic           cmd_logical,
  input  logic [1:0]     cmd_sh,
  input  logic [2:0]     cmd_dm,
  input  logic [SW-1:0]  cmd_src,
  input  logic [8*N-1:0] tgt_phys_id,
  input  logic [8*N-1:0] tgt_log_id,
  input  logic [2*N-1:0] tgt_model,
  input  logic [N-1:0]   tgt_enable,
  output logic           res_valid,
  output logic [N-1:0]   res_mask,
  output logic [N-1:0]   res_lowest,
  output logic           res_model_err
);
  localparam logic [1:0] SH_NONE = 2'd0, SH_SELF = 2'd1, SH_ALL = 2'd2;
  localparam logic [1:0] MD_FLAT = 2'd0, MD_CLUSTER = 2'd1;
  localparam logic [2:0] DM_LOWEST = 3'd1;

  logic [N-1:0] hit, pick;
  logic         bad;
  logic         r_lp;

  always_comb begin
    hit = '0;
    bad = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic [7:0] pid, lid;
      logic       is_src;
      pid    = tgt_phys_id[8*i +: 8];
      lid    = tgt_log_id[8*i +: 8];
      is_src = (SW'(i) == cmd_src);
      case (cmd_sh)
        SH_NONE: begin
          if (!cmd_logical)
            hit[i] = (cmd_dest == 8'hFF) || (cmd_dest == pid);
          else begin
            case (tgt_model[2*i +: 2])
              MD_FLAT:    hit[i] = |(lid & cmd_dest);
              MD_CLUSTER: hit[i] = (lid[7:4] == cmd_dest[7:4]) && |(lid[3:0] & cmd_dest[3:0]);
              default: begin
                hit[i] = 1'b0;
                if (tgt_enable[i]) bad = 1'b1;
              end
            endcase
          end
        end
        SH_SELF: hit[i] = is_src;
        SH_ALL:  hit[i] = 1'b1;
        default: hit[i] = !is_src;
      endcase
    end
    hit = hit & tgt_enable;
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) pick = N'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_mask      <= '0;
      res_lowest    <= '0;
      res_model_err <= 1'b0;
      r_lp          <= 1'b0;
    end else begin
      res_valid     <= cmd_valid;
      res_mask      <= cmd_valid ? hit : '0;
      res_lowest    <= (cmd_valid && cmd_dm == DM_LOWEST) ? pick : '0;
      res_model_err <= cmd_valid && bad;
      r_lp          <= cmd_valid && cmd_dm == DM_LOWEST;
    end
  end

  AST_LOWEST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_lowest)); // R9
  AST_LOWEST_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_lowest & ~res_mask) == '0); // R9
  AST_LOWEST_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_lp && res_mask != '0) |-> res_lowest != '0); // R9
  AST_DISABLED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (res_mask & ~$past(tgt_enable)) == '0); // R8
  AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_sh == SH_SELF) |=> $countones(res_mask) <= 1); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_mask == '0 && res_lowest == '0 && !res_model_err)); // R10
endmodule

// File: tb/ipi_dest_match_test.sv
module ipi_dest_match_test;
  localparam int N = 8;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_logical = 0;
  logic [7:0] cmd_dest = 0;
  logic [1:0] cmd_sh = 0;
  logic [2:0] cmd_dm = 0;
  logic [SW-1:0] cmd_src = 0;
  logic [8*N-1:0] tgt_phys_id, tgt_log_id;
  logic [2*N-1:0] tgt_model;
  logic [N-1:0] tgt_enable;
  logic res_valid, res_model_err;
  logic [N-1:0] res_mask, res_lowest;

  ipi_dest_match #(.N(N)) uut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [N-1:0] mask; logic [N-1:0] low; logic err; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(string tag, logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] dm, logic [SW-1:0] src);
    exp_t e;
    e.mask = '0; e.low = '0; e.err = 0; e.tag = tag;
    for (int i = 0; i < N; i++) begin
      logic m;
      logic [7:0] p, l;
      p = tgt_phys_id[8*i +: 8];
      l = tgt_log_id[8*i +: 8];
      m = 0;
      if (sh == 2'd1) m = (i == int'(src));
      else if (sh == 2'd2) m = 1;
      else if (sh == 2'd3) m = (i != int'(src));
      else if (!lg) m = (d == 8'hFF) || (d == p);
      else if (tgt_model[2*i +: 2] == 2'd0) m = (l & d) != 0;
      else if (tgt_model[2*i +: 2] == 2'd1) m = (l[7:4] == d[7:4]) && ((l[3:0] & d[3:0]) != 0);
      else if (tgt_enable[i]) e.err = 1;
      if (m && tgt_enable[i]) e.mask[i] = 1;
    end
    if (dm == 3'd1)
      for (int i = 0; i < N; i++) if (e.mask[i]) e.low = N'(1) << i;
    @(negedge clk);
    cmd_valid = 1; cmd_dest = d; cmd_logical = lg; cmd_sh = sh; cmd_dm = dm; cmd_src = src;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    @(negedge clk);
    while (!done) begin
      if (rst_n) begin
        if (res_valid) begin
          if (sb.size() == 0) chk("R10", "unexpected valid", 1, 0);
          else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "mask", 32'(res_mask), 32'(e.mask));
            chk(e.tag, "lowest", 32'(res_lowest), 32'(e.low));
            chk(e.tag, "err", 32'(res_model_err), 32'(e.err));
          end
        end else if (res_mask != 0 || res_lowest != 0 || res_model_err)
          chk("R10", "idle outputs", {res_mask, res_lowest, res_model_err}, 0);
      end
      @(negedge clk);
    end
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      tgt_phys_id[8*i +: 8] = 8'h10 + 8'(i);
      tgt_log_id[8*i +: 8]  = 8'(1 << i);
      tgt_model[2*i +: 2]   = 2'd0;
    end
    tgt_enable = '1;
    repeat (3) @(negedge clk);
    chk("R10", "reset valid", 32'(res_valid), 0);
    chk("R10", "reset mask", 32'(res_mask), 0);
    rst_n = 1;
    send("R1", 8'h13, 0, 2'd0, 3'd0, 0);
    send("R1", 8'hFF, 0, 2'd0, 3'd0, 0);
    send("R1", 8'h55, 0, 2'd0, 3'd0, 0);
    send("R2", 8'h0A, 1, 2'd0, 3'd0, 0);
    send("R5", 8'h13, 0, 2'd1, 3'd0, 5);
    send("R6", 8'h00, 1, 2'd2, 3'd0, 2);
    send("R7", 8'h00, 0, 2'd3, 3'd0, 0);
    send("R9", 8'h0A, 1, 2'd0, 3'd1, 0);
    send("R9", 8'h55, 0, 2'd0, 3'd1, 0);
    send("R9", 8'hFF, 0, 2'd0, 3'd1, 0);
    send("R9", 8'hFF, 0, 2'd0, 3'd2, 0);
    tgt_enable = 8'h3F;
    send("R8", 8'hFF, 0, 2'd0, 3'd1, 0);
    send("R8", 8'h00, 0, 2'd2, 3'd1, 0);
    tgt_enable = '1;
    for (int i = 0; i < N; i++) begin
      tgt_model[2*i +: 2] = 2'd1;
      tgt_log_id[8*i +: 8] = {4'(i / 4 + 2), 4'(1 << (i % 4))};
    end
    send("R3", 8'h23, 1, 2'd0, 3'd0, 0);
    send("R3", 8'h3C, 1, 2'd0, 3'd1, 0);
    send("R3", 8'h4F, 1, 2'd0, 3'd0, 0);
    tgt_model[2*2 +: 2] = 2'd2;
    tgt_model[2*6 +: 2] = 2'd3;
    send("R4", 8'h24, 1, 2'd0, 3'd0, 0);
    send("R4", 8'h12, 0, 2'd0, 3'd0, 0);
    tgt_enable = 8'hBB;
    send("R4", 8'h2F, 1, 2'd0, 3'd0, 0);
    repeat (4) @(negedge clk);
    chk("R10", "scoreboard drained", 32'(sb.size()), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule